// File: doc/BRIEF.md
# Tick-Driven Fixed-Period PWM Pair

This block generates a fixed-period pulse-width waveform on each of two channels. A channel's counter does not advance on every clock. It advances only on single-cycle enable pulses from an upstream variable-frequency generator, so the upstream rate sets the tick rate. Each channel has an 8-bit period value and an 8-bit on-count. The period lasts period+1 ticks, and the output is high during the first on-count of those ticks.

Each channel has a 4-bit control field in one shared control word. The fields sit at a 4-bit stride. The bits of a field are start, an active-low output enable, force-high and open-drain mode. A per-channel output-select bit picks between the PWM waveform and the raw upstream square wave. The result drives a pad as a data bit plus an output enable.

When software enables a channel it clears the output-enable-bar bit and sets start and open-drain. When it disables a channel it does the reverse. The bus decoding and the upstream frequency generator are outside this block.

Top module: `tpwm_pair`

## Requirements
- R1: With start set, a channel's counter advances by one only on cycles where its tick input is high. It steps 0, 1, …, P and then returns to 0, where P is the latched period value, so one period spans P+1 ticks. The PWM level is high while the count is below the latched on-count N.
- R2: While start (control field bit 0) is clear, the counter is held at 0 and the PWM level is low.
- R3: If N is greater than P, the PWM level stays high on every tick (for example N=0xFF with P=0xFE). With P=0 the period is one tick, and the level is high if and only if N is at least 1.
- R4: When output-select port bit ch (which stands for select register bit 4·ch) is 1, the channel drives its PWM level. When that bit is 0, the channel drives its upstream square-wave input unchanged.
- R5: Force-high (control field bit 2) drives the pad data high, whatever start, select or the waveforms are.
- R6: In open-drain mode (control field bit 3 set), the pad output enable is high exactly when the pad data is low. In push-pull mode the pad output enable equals the inverse of output-enable-bar (control field bit 1).
- R7: If the period or on-count inputs change while the channel runs, the new values take effect only after the counter wraps back to 0. While the channel is stopped, the inputs are latched on every clock.
- R8: Channel ch uses control-word bits 4·ch to 4·ch+3. Changing one channel's field has no effect on the other channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 2 | Per-channel upstream enable pulse |
| vf_sq_i | input | 2 | Per-channel upstream square wave |
| ctrl_i | input | 8 | Shared control word, 4 bits per channel |
| sel_i | input | 2 | Output select per channel (1 = PWM) |
| per_i | input | 16 | Period values, 8 bits per channel |
| on_i | input | 16 | On-counts, 8 bits per channel |
| pad_do_o | output | 2 | Pad data per channel |
| pad_oe_o | output | 2 | Pad output enable per channel |

## Verification
The bench goes after the wrap point. A counter that ran P ticks or P+2 ticks per period would shift every later high pulse, so the bench compares the output against a modulo model tick by tick. It changes the on-count in the middle of a period. A design that loaded the new value at once would go high before the wrap. It checks the full-on case N>P and the one-tick case P=0. An off-by-one compare would show a one-tick low pulse in the first case, or a stuck level in the second. It also restarts a stopped channel to catch a counter that is not cleared. It sets one channel's force-high bit to catch control fields decoded at the wrong stride.

// File: rtl/tpwm_pkg.sv
// Package: shared field layout for the tick-driven PWM pair.
// Assumes a control field of 4 bits per channel, with start in the lowest bit.
package tpwm_pkg;
    localparam int unsigned FLD_W = 4;

    // Control field as seen by one channel; bit 0 is start
    typedef struct packed {
        logic od;     // bit 3: open-drain pad drive
        logic fh;     // bit 2: force data high
        logic oeb;    // bit 1: output enable, active low
        logic start;  // bit 0: run the counter
    } ctrl_fld_t;
endpackage

// File: rtl/tpwm_counter.sv
// Module: tick counter with shadowed period/on-count and duty compare.
// Assumes tick_i is a single-cycle enable. The shadows track the inputs
// while the channel is stopped and reload only at the wrap while it runs.
module tpwm_counter #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic [CW-1:0] per_i,
    input  logic [CW-1:0] on_i,
    output logic          pwm_o
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] per_q;
    logic [CW-1:0] on_q;
    logic          at_end;

    assign at_end = (cnt_q == per_q);

    // Counter: hold at zero when stopped; on a tick, step or wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

    // Shadows: follow the inputs when stopped, reload at the period wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
            on_q  <= '0;
        end else if (!run_i || (tick_i && at_end)) begin
            per_q <= per_i;
            on_q  <= on_i;
        end
    end

    // Duty compare: high for the first on_q counts of each period
    always_comb begin
        pwm_o = run_i && (cnt_q < on_q);
    end
endmodule

// File: rtl/tpwm_padmux.sv
// Module: output select, force-high override and pad drive shaping.
// Purely combinational. Assumes the inputs come from registered state or from block inputs.
module tpwm_padmux (
    input  logic pwm_i,
    input  logic sq_i,
    input  logic sel_i,
    input  logic fh_i,
    input  logic od_i,
    input  logic oeb_i,
    output logic do_o,
    output logic oe_o
);
    // Data: force-high wins, otherwise the selected waveform
    always_comb begin
        if (fh_i) do_o = 1'b1;
        else      do_o = sel_i ? pwm_i : sq_i;
    end

    // Enable: open drain drives only a low; push-pull follows the enable bit
    always_comb begin
        oe_o = od_i ? ~do_o : ~oeb_i;
    end
endmodule

// File: rtl/tpwm_pair.sv
// Top: NCH tick-driven PWM channels sharing one control word.
// Assumes per-channel control fields at a stride of FLD_W bits, and
// per-channel period and on-count slices of CW bits.
module tpwm_pair
    import tpwm_pkg::*;
#(
    parameter int unsigned NCH = 2,
    parameter int unsigned CW  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       tick_i,
    input  logic [NCH-1:0]       vf_sq_i,
    input  logic [FLD_W*NCH-1:0] ctrl_i,
    input  logic [NCH-1:0]       sel_i,
    input  logic [CW*NCH-1:0]    per_i,
    input  logic [CW*NCH-1:0]    on_i,
    output logic [NCH-1:0]       pad_do_o,
    output logic [NCH-1:0]       pad_oe_o
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        ctrl_fld_t fld;
        logic      pwm;

        assign fld = ctrl_fld_t'(ctrl_i[ch*FLD_W +: FLD_W]);

        tpwm_counter #(.CW(CW)) cnt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_i  (fld.start),
            .tick_i (tick_i[ch]),
            .per_i  (per_i[ch*CW +: CW]),
            .on_i   (on_i[ch*CW +: CW]),
            .pwm_o  (pwm)
        );

        tpwm_padmux mux_i (
            .pwm_i (pwm),
            .sq_i  (vf_sq_i[ch]),
            .sel_i (sel_i[ch]),
            .fh_i  (fld.fh),
            .od_i  (fld.od),
            .oeb_i (fld.oeb),
            .do_o  (pad_do_o[ch]),
            .oe_o  (pad_oe_o[ch])
        );
    end
endmodule

// File: rtl/tpwm_pair_chk.sv
// Checker: port-level properties of tpwm_pair, attached by bind.
module tpwm_pair_chk
    import tpwm_pkg::*;
#(
    parameter int unsigned NCH = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCH-1:0]       vf_sq_i,
    input logic [FLD_W*NCH-1:0] ctrl_i,
    input logic [NCH-1:0]       sel_i,
    input logic [NCH-1:0]       pad_do_o,
    input logic [NCH-1:0]       pad_oe_o
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_i[ch*FLD_W+2] |-> pad_do_o[ch]);                          // R5
        AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl_i[ch*FLD_W] && !ctrl_i[ch*FLD_W+2] && sel_i[ch]) |-> !pad_do_o[ch]); // R2
        AST_SEL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl_i[ch*FLD_W+2] && !sel_i[ch]) |-> (pad_do_o[ch] == vf_sq_i[ch])); // R4
        AST_OD_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_i[ch*FLD_W+3] |-> (pad_oe_o[ch] != pad_do_o[ch]));        // R6
        AST_PP_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_i[ch*FLD_W+3] |-> (pad_oe_o[ch] == !ctrl_i[ch*FLD_W+1])); // R6
    end
endmodule

bind tpwm_pair tpwm_pair_chk #(.NCH(NCH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .vf_sq_i  (vf_sq_i),
    .ctrl_i   (ctrl_i),
    .sel_i    (sel_i),
    .pad_do_o (pad_do_o),
    .pad_oe_o (pad_oe_o)
);

// File: tb/tpwm_pair_tb_top.sv
// Directed bench for tpwm_pair: one task per scenario, each task checking its own results.
module tpwm_pair_tb_top;
    localparam int NCH = 2;
    localparam int CW  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    tick_i = '0;
    logic [NCH-1:0]    vf_sq_i = '0;
    logic [4*NCH-1:0]  ctrl_i = '0;
    logic [NCH-1:0]    sel_i = '0;
    logic [CW*NCH-1:0] per_i = '0;
    logic [CW*NCH-1:0] on_i = '0;
    logic [NCH-1:0]    pad_do_o;
    logic [NCH-1:0]    pad_oe_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tpwm_pair #(.NCH(NCH), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .vf_sq_i(vf_sq_i),
        .ctrl_i(ctrl_i), .sel_i(sel_i), .per_i(per_i), .on_i(on_i),
        .pad_do_o(pad_do_o), .pad_oe_o(pad_oe_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Wait one clock and come back 1 ns after the edge
    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic set_fld(input int ch, input bit start, input bit oeb, input bit fh, input bit od);
        ctrl_i[ch*4 +: 4] = {od, fh, oeb, start};
    endtask

    // Stop, load values while stopped, then start with select on the PWM
    task automatic cfg(input int ch, input int per, input int on);
        set_fld(ch, 0, 0, 0, 0);
        per_i[ch*CW +: CW] = per[CW-1:0];
        on_i[ch*CW +: CW]  = on[CW-1:0];
        sel_i[ch] = 1'b1;
        cyc();
        set_fld(ch, 1, 0, 0, 0);
    endtask

    task automatic tick(input int ch);
        tick_i[ch] = 1'b1;
        cyc();
        tick_i[ch] = 1'b0;
    endtask

    task automatic t_reset();
        check("R2 reset data", pad_do_o, 0);
        check("R6 reset oe", pad_oe_o, 3);
    endtask

    // R1: walk several periods against a modulo model
    task automatic t_period(input int per, input int on, input int n);
        cfg(0, per, on);
        #1;
        check("R1 start level", pad_do_o[0], (0 < on) ? 1 : 0);
        for (int k = 1; k <= n; k++) begin
            tick(0);
            check("R1 tick level", pad_do_o[0], ((k % (per + 1)) < on) ? 1 : 0);
        end
        repeat (3) cyc();
        check("R1 hold without tick", pad_do_o[0], ((n % (per + 1)) < on) ? 1 : 0);
    endtask

    task automatic t_full();
        int lows;
        lows = 0;
        cfg(0, 8'hFE, 8'hFF);
        for (int k = 0; k < 600; k++) begin
            tick(0);
            if (!pad_do_o[0]) lows++;
        end
        check("R3 full-on lows", lows, 0);
        cfg(0, 0, 1);
        tick(0); check("R3 P=0 N=1 high", pad_do_o[0], 1);
        tick(0); check("R3 P=0 N=1 high again", pad_do_o[0], 1);
        cfg(0, 0, 0);
        tick(0); check("R3 P=0 N=0 low", pad_do_o[0], 0);
    endtask

    task automatic t_stop();
        cfg(0, 3, 1);
        tick(0); tick(0);
        check("R2 running mid-period low", pad_do_o[0], 0);
        set_fld(0, 0, 0, 0, 0);
        tick(0); tick(0);
        check("R2 stopped low", pad_do_o[0], 0);
        set_fld(0, 1, 0, 0, 0); #1;
        check("R2 restart from zero", pad_do_o[0], 1);
        tick(0);
        check("R2 restart count one", pad_do_o[0], 0);
    endtask

    task automatic t_sel();
        cfg(0, 3, 2);
        sel_i[0] = 1'b0;
        vf_sq_i[0] = 1'b0; #1;
        check("R4 pass low", pad_do_o[0], 0);
        vf_sq_i[0] = 1'b1; #1;
        check("R4 pass high", pad_do_o[0], 1);
        vf_sq_i[0] = 1'b0;
        sel_i[0] = 1'b1; #1;
        check("R4 select pwm", pad_do_o[0], 1);
    endtask

    task automatic t_force();
        set_fld(0, 0, 0, 1, 0);
        sel_i[0] = 1'b1; #1;
        check("R5 force while stopped", pad_do_o[0], 1);
        sel_i[0] = 1'b0; vf_sq_i[0] = 1'b0; #1;
        check("R5 force over passthrough", pad_do_o[0], 1);
        set_fld(0, 0, 0, 0, 0);
    endtask

    task automatic t_pad();
        cfg(0, 3, 1);
        set_fld(0, 1, 0, 0, 1); #1;
        check("R6 od data high oe", pad_oe_o[0], 0);
        tick(0);
        check("R6 od data low oe", pad_oe_o[0], 1);
        set_fld(0, 1, 1, 0, 0); #1;
        check("R6 push-pull oeb set", pad_oe_o[0], 0);
        set_fld(0, 1, 0, 0, 0); #1;
        check("R6 push-pull oeb clear", pad_oe_o[0], 1);
    endtask

    task automatic t_shadow();
        cfg(0, 3, 1);
        tick(0);
        on_i[0 +: CW] = 8'd4;
        check("R7 old on-count kept", pad_do_o[0], 0);
        tick(0); check("R7 count2 still old", pad_do_o[0], 0);
        tick(0); check("R7 count3 still old", pad_do_o[0], 0);
        tick(0); check("R7 wrap new", pad_do_o[0], 1);
        tick(0); check("R7 new value count1", pad_do_o[0], 1);
        set_fld(0, 0, 0, 0, 0);
        on_i[0 +: CW] = 8'd0;
        cyc();
        set_fld(0, 1, 0, 0, 0); #1;
        check("R7 stopped load immediate", pad_do_o[0], 0);
    endtask

    task automatic t_chan();
        cfg(0, 3, 1);
        cfg(1, 3, 1);
        tick(0);
        set_fld(1, 1, 0, 1, 0); #1;
        check("R8 ch1 force", pad_do_o[1], 1);
        check("R8 ch0 unaffected", pad_do_o[0], 0);
        set_fld(1, 0, 0, 0, 0); #1;
        tick(0); tick(0); tick(0);
        check("R8 ch0 wraps alone", pad_do_o[0], 1);
        check("R8 ch1 stopped", pad_do_o[1], 0);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_period(3, 1, 9);
        t_period(4, 3, 11);
        t_period(6, 6, 15);
        t_full();
        t_stop();
        t_sel();
        t_force();
        t_pad();
        t_shadow();
        t_chan();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule